// File: doc/BRIEF.md
# Time-Multiplexed FIR Filter Engine

This block computes a finite impulse response filter with a single multiply-accumulate datapath that is reused once per tap for every input sample. Samples arrive on a valid/ready stream and are written into a circular sample store. Coefficients live in a separate writable store with their own address port. For each accepted sample, a sequencer walks the sample store backwards from the newest entry while stepping the coefficient index forwards from zero. The accumulator restarts on the first tap, and the finished sum is captured into a registered output.

Because one product is formed per clock, the block takes one sample every `TAPS` clocks at most. A new sample is accepted in the cycle the previous computation issues its last tap, so a continuously valid input stream runs at exactly that rate. Coefficients can be rewritten at run time whenever the engine is ready for a sample. Both stores are synchronous single-write, single-read arrays that map onto block RAM.

Top module: `tdm_fir`

## Requirements
- R1: While and directly after synchronous reset `rst` is high, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R2: For the n-th accepted sample x[n], the result is the sum over k = 0..TAPS-1 of c[k]·x[n-k], where coefficient index 0 multiplies the newest sample. Products are full-precision signed, and the sum is presented as an ACC_W-bit two's complement value.
- R3: Sample positions older than the first sample accepted after reset contribute zero to the sum.
- R4: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. After that edge `in_ready` is 0 for TAPS-1 cycles and then 1, so accepted samples are exactly TAPS cycles apart when `in_valid` stays high.
- R5: `out_valid` is high for exactly one cycle, after the rising edge that comes TAPS+2 edges after the accepting edge, and is never high at any other time.
- R6: `out_data` holds its value in every cycle where `out_valid` is 0.
- R7: On a rising edge with `coef_we` = 1, `in_ready` = 1 and `coef_addr` < TAPS, `coef_data` becomes coefficient c[`coef_addr`]. It applies to a sample accepted on that same edge and to all later samples.
- R8: A coefficient write on an edge where `in_ready` is 0 is ignored, and later results still use the old coefficient.
- R9: The sample store is circular with depth TAPS, so each result uses only the latest TAPS samples, including after the write position wraps many times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is presented |
| in_sample | input | SAMPLE_W | Signed input sample |
| in_ready | output | 1 | Engine can take a sample (and a coefficient write) this cycle |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Coefficient index to write |
| coef_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_data | output | ACC_W | Signed filter result, held between strobes |

## Verification
The bench builds the block with its default parameters: 31 taps, 12-bit samples, 11-bit coefficients and a 27-bit accumulator. A tap count that is not a power of two exercises the explicit modulo wrap of both pointers. Streams of 70 samples wrap the circular store twice. Filling 31 taps with the most negative sample and coefficient drives the sum to 65,011,712, close to the top of the 27-bit range. A free-running reference model in the bench predicts `in_ready` on every cycle, so the coefficient-write gate is tested both in the middle of a computation and on the cycle that issues the last tap.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // Per-tap control token that travels alongside the memory read data
  typedef struct packed {
    logic first;   // restart the accumulator
    logic last;    // final tap of the computation
    logic live;    // sample position holds real history
  } tap_tag_t;
endpackage

// File: rtl/fir_dpram.sv
module fir_dpram #(
  parameter int DEPTH = 31,
  parameter int WIDTH = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [0:DEPTH-1];

  // Registered read returns the old word on a same-address collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_tap_seq.sv
module fir_tap_seq
  import fir_pkg::*;
#(
  parameter int TAPS = 31,
  localparam int PW  = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int FW  = $clog2(TAPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic [PW-1:0] wr_addr,
  output logic [PW-1:0] rd_addr,
  output logic [PW-1:0] cf_addr,
  output logic          issue_vld,
  output tap_tag_t      issue_tag
);
  localparam logic [PW-1:0] LAST = PW'(TAPS - 1);

  logic          busy;
  logic [PW-1:0] k;
  logic [PW-1:0] newest;
  logic [FW-1:0] filled;
  logic          last_k;

  assign last_k   = (k == LAST);
  assign in_ready = !busy || last_k;
  assign accept   = in_valid && in_ready;
  assign wr_addr  = (newest == LAST) ? '0 : newest + 1'b1;

  // Newest sample minus tap index, modulo TAPS
  assign rd_addr  = (newest >= k) ? newest - k : newest + PW'(TAPS) - k;
  assign cf_addr  = k;

  assign issue_vld       = busy;
  assign issue_tag.first = (k == '0);
  assign issue_tag.last  = last_k;
  assign issue_tag.live  = (FW'(k) < filled);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      k      <= '0;
      newest <= LAST;
      filled <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      k      <= '0;
      newest <= wr_addr;
      if (filled != FW'(TAPS)) filled <= filled + 1'b1;
    end else if (busy) begin
      if (last_k) busy <= 1'b0;
      else        k    <= k + 1'b1;
    end
  end

  p_accept_starts_r4: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && k == '0));
  p_no_early_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_k) |=> busy);
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
    filled <= FW'(TAPS));
endmodule

// File: rtl/fir_mac_acc.sv
module fir_mac_acc
  import fir_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 11,
  parameter int ACC_W    = 27,
  localparam int PRD_W   = SAMPLE_W + COEF_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       vld,
  input  tap_tag_t                   tag,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic signed [COEF_W-1:0]   cof,
  output logic                       out_valid,
  output logic signed [ACC_W-1:0]    out_data
);
  logic signed [PRD_W-1:0] prod;
  logic signed [ACC_W-1:0] prod_x;
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] acc;
  logic                    done;

  assign prod   = smp * cof;
  assign prod_x = {{(ACC_W-PRD_W){prod[PRD_W-1]}}, prod};
  assign addend = tag.live ? prod_x : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      done      <= vld && tag.last;
      out_valid <= done;
      if (vld)  acc      <= (tag.first ? '0 : acc) + addend;
      if (done) out_data <= acc;
    end
  end

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  p_last_to_out_r5: assert property (@(posedge clk) disable iff (rst)
    (vld && tag.last) |-> ##2 out_valid);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

// File: rtl/tdm_fir.sv
module tdm_fir
  import fir_pkg::*;
#(
  parameter int TAPS     = 31,
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 11,
  parameter int ACC_W    = 27,
  localparam int PW      = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                in_ready,
  input  logic                coef_we,
  input  logic [PW-1:0]       coef_addr,
  input  logic [COEF_W-1:0]   coef_data,
  output logic                out_valid,
  output logic [ACC_W-1:0]    out_data
);
  localparam logic [PW-1:0] LAST = PW'(TAPS - 1);

  logic                accept;
  logic [PW-1:0]       wr_addr, rd_addr, cf_addr;
  logic                issue_vld;
  tap_tag_t            issue_tag;
  logic [SAMPLE_W-1:0] smp_q;
  logic [COEF_W-1:0]   cof_q;
  logic                vld_q;
  tap_tag_t            tag_q;
  logic                cf_we;

  // Coefficient writes only land while the engine can take a sample
  assign cf_we = coef_we && in_ready && (coef_addr <= LAST);

  fir_tap_seq #(.TAPS(TAPS)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .wr_addr(wr_addr), .rd_addr(rd_addr), .cf_addr(cf_addr),
    .issue_vld(issue_vld), .issue_tag(issue_tag)
  );

  fir_dpram #(.DEPTH(TAPS), .WIDTH(SAMPLE_W)) u_smp_mem (
    .clk(clk), .we(accept), .waddr(wr_addr), .wdata(in_sample),
    .raddr(rd_addr), .rdata(smp_q)
  );

  fir_dpram #(.DEPTH(TAPS), .WIDTH(COEF_W)) u_cof_mem (
    .clk(clk), .we(cf_we), .waddr(coef_addr), .wdata(coef_data),
    .raddr(cf_addr), .rdata(cof_q)
  );

  // Token pipeline matching the one-cycle memory read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else begin
      vld_q <= issue_vld;
      tag_q <= issue_tag;
    end
  end

  fir_mac_acc #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .vld(vld_q), .tag(tag_q),
    .smp(smp_q), .cof(cof_q),
    .out_valid(out_valid), .out_data(out_data)
  );

  p_tag_follows_issue_r2: assert property (@(posedge clk) disable iff (rst)
    issue_vld |=> vld_q);
endmodule

// File: tb/test_tdm_fir.sv
`timescale 1ns/1ps
module test_tdm_fir;
  localparam int T  = 31;
  localparam int SW = 12;
  localparam int CW = 11;
  localparam int AW = 27;
  localparam int PW = $clog2(T);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic          in_ready;
  logic          coef_we = 1'b0;
  logic [PW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic          out_valid;
  logic [AW-1:0] out_data;

  always #2.5 clk = ~clk;

  tdm_fir i_tdm_fir (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_ready(in_ready), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
  );

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  int     since  = 1000;
  int     cf [T];
  int     hist [$];
  longint due_q [$];
  longint val_q [$];
  longint last_out = 0;
  string  scen = "init";

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint got_out();
    logic signed [AW-1:0] v;
    v = out_data;
    return longint'(v);
  endfunction

  function automatic longint model_y();
    longint s = 0;
    for (int i = 0; i < hist.size(); i++) s += longint'(cf[i]) * longint'(hist[i]);
    return s;
  endfunction

  // One clock of stimulus, reference model update and output check
  task automatic step(bit v, int s, bit we, int a, int d, output bit took);
    bit rdy, exp_rdy;
    longint g;
    in_valid = v; in_sample = SW'(s);
    coef_we = we; coef_addr = PW'(a); coef_data = CW'(d);
    exp_rdy = (since >= T - 1);
    rdy = in_ready;
    chk(rdy == exp_rdy, {scen, " R4 in_ready"}, longint'(rdy), longint'(exp_rdy));
    @(posedge clk);
    cyc++;
    if (we && rdy && a < T) cf[a] = d;
    took = v && rdy;
    if (took) begin
      hist.push_front(s);
      if (hist.size() > T) void'(hist.pop_back());
      due_q.push_back(cyc + T + 2);
      val_q.push_back(model_y());
      since = 0;
    end else begin
      since++;
    end
    @(negedge clk);
    g = got_out();
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      chk(out_valid == 1'b1, {scen, " R5 out_valid at T+2"}, longint'(out_valid), 1);
      chk(g == val_q[0], {scen, " R2 result"}, g, val_q[0]);
      last_out = val_q[0];
      void'(due_q.pop_front());
      void'(val_q.pop_front());
    end else begin
      chk(out_valid == 1'b0, {scen, " R5 no stray strobe"}, longint'(out_valid), 0);
      chk(g == last_out, {scen, " R6 held output"}, g, last_out);
    end
    in_valid = 1'b0; coef_we = 1'b0;
  endtask

  task automatic send(int s);
    bit took;
    do step(1'b1, s, 1'b0, 0, 0, took); while (!took);
  endtask

  task automatic drain();
    bit took;
    while (due_q.size() > 0) step(1'b0, 0, 1'b0, 0, 0, took);
  endtask

  task automatic load_coefs(int kind);
    bit took;
    for (int k = 0; k < T; k++) begin
      int c;
      case (kind)
        0:       c = k + 1;
        1:       c = -1024;
        default: c = ((k * 37) % 2047) - 1023;
      endcase
      step(1'b0, 0, 1'b1, k, c, took);
    end
  endtask

  task automatic t_reset();
    scen = "reset";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(out_data == '0, "R1 out_data in reset", got_out(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R1 state after release", got_out(), 0);
  endtask

  task automatic t_impulse();
    scen = "R3 impulse";
    load_coefs(0);
    send(1);
    for (int i = 0; i < T; i++) send(0);
    drain();
  endtask

  task automatic t_extreme();
    scen = "R2 extremes";
    load_coefs(1);
    for (int i = 0; i < T; i++) send(-2048);
    drain();
    chk(last_out == 64'sd65011712, "R2 full-scale sum", last_out, 65011712);
  endtask

  task automatic t_wrap();
    scen = "R9 wrap";
    load_coefs(2);
    for (int i = 0; i < 70; i++) send(((i * 911) % 4095) - 2047);
    drain();
  endtask

  task automatic t_busy_write();
    bit took;
    scen = "R8 busy write";
    send(100);
    step(1'b0, 0, 1'b1, 0, 555, took);
    step(1'b0, 0, 1'b1, 5, -321, took);
    drain();
    send(7);
    drain();
  endtask

  task automatic t_ready_write();
    bit took;
    scen = "R7 write at accept";
    step(1'b1, 300, 1'b1, 0, -77, took);
    drain();
    scen = "R7 write on last tap";
    send(5);
    while (!in_ready) step(1'b0, 0, 1'b0, 0, 0, took);
    step(1'b0, 0, 1'b1, 1, -500, took);
    drain();
    send(9);
    send(-3);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_impulse();
    t_extreme();
    t_wrap();
    t_busy_write();
    t_ready_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule